// File: doc/BRIEF.md
# Table-Coded Programmable Clock Divider

This block derives a slower clock from one of three source clocks. A small code field sets the division ratio. The code does not scale linearly: it goes through a lookup chosen by a parameter. The four lookups are a doubling series, a quadrupling series, an engine series and a MAC series. In the engine and MAC series, two low codes give the same ratio. A two-bit select field picks the source, and a gate enable stops the divider.

The whole block runs on one system clock. Each source is presented as a one-cycle tick strobe on `src_tick`, and the divider counts ticks of the selected source. The output level is registered. Even ratios give an equal high and low time. For odd ratios the high phase is one source tick longer than the low phase.

A new code or source select written mid-period has no effect on the current period. It is taken into an internal shadow copy at the start of the next high phase. While the gate is off, the shadow copy follows the inputs directly.

Top module: `coded_clk_div`

## Requirements
- R1: With VARIANT 0 (doubling), code n divides by 2·(n+1): codes 0 to 7 give ratios 2 to 16 in steps of 2.
- R2: With VARIANT 1 (quadrupling), code n divides by 4·(n+1): codes 0 to 7 give ratios 4 to 32 in steps of 4.
- R3: With VARIANT 2 (engine), codes 0 and 1 both divide by 2, and code n from 2 to 7 divides by n+1.
- R4: With VARIANT 3 (MAC), codes 0 and 1 both divide by 4, and code n from 2 to 7 divides by 2·(n+1).
- R5: For ratio R, the output stays high for ceil(R/2) selected ticks and low for floor(R/2) selected ticks.
- R6: Select value 0, 1 or 2 makes `src_tick` bit 0 (memory PLL), bit 1 (high-speed PLL) or bit 2 (display PLL) the counted source. Value 3 counts bit 0. Ticks on bits that are not selected are ignored.
- R7: A change of `div_code` or `src_sel` while the output runs leaves the current period unchanged. The new value sets the ratio and source only from the next rising edge of the output.
- R8: With `gate_en` low, the output is low one clock later and the count is cleared. After `gate_en` returns high, the first selected tick drives the output high and starts a full period.
- R9: With the gate on, the output changes only on a clock edge where a tick is present on the selected source.
- R10: While reset is asserted, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| src_tick | input | NSRC | One-cycle tick strobes, one per source clock |
| src_sel | input | SEL_W | Source select |
| div_code | input | CODE_W | Division code, mapped through the variant's lookup |
| gate_en | input | 1 | Gate enable; low stops the divider and holds the output low |
| div_out | output | 1 | Divided clock level |

## Verification
On every cycle, the assertions check four things. Gating forces the output low. A rising edge needs an enabled gate and a tick. With no tick, the output holds. The shadowed code and select change only at a rising edge or while the gate is off. The ratio lookups, the duty split of odd ratios, the mapping of select value 3 and the ignoring of unselected sources can be shown only by the bench. It measures whole output periods under fixed stimulus, one scenario per variant, code and source. It also confirms that a code change in mid-period stretches nothing until the next rise.

// File: rtl/coded_clk_div.sv
module coded_clk_div #(
  parameter int VARIANT = 0,
  parameter int CODE_W  = 3,
  parameter int SEL_W   = 2,
  parameter int NSRC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              gate_en,
  output logic              div_out
);
  localparam int NCODE = 2 ** CODE_W;
  localparam int MAX_R = (VARIANT == 1) ? 4 * NCODE : 2 * NCODE;
  localparam int CW    = $clog2(MAX_R);

  function automatic logic [CW:0] ratio_of(input logic [CODE_W-1:0] c);
    int n;
    int r;
    n = int'(c);
    case (VARIANT)
      1:       r = 4 * (n + 1);
      2:       r = (n < 2) ? 2 : n + 1;
      3:       r = (n < 2) ? 4 : 2 * (n + 1);
      default: r = 2 * (n + 1);
    endcase
    return (CW + 1)'(r);
  endfunction

  logic [CW-1:0]     cnt;
  logic              run;
  logic [CODE_W-1:0] act_code;
  logic [SEL_W-1:0]  act_sel;

  logic [CW:0] act_r, hi_len, nxt;
  logic        tick, wrap;

  assign act_r  = ratio_of(act_code);
  assign hi_len = (act_r + 1'b1) >> 1;
  assign nxt    = {1'b0, cnt} + 1'b1;
  assign wrap   = !run || (nxt == act_r);
  assign tick   = (int'(act_sel) < NSRC) ? src_tick[act_sel] : src_tick[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      run      <= 1'b0;
      div_out  <= 1'b0;
      act_code <= '0;
      act_sel  <= '0;
    end else if (!gate_en) begin
      cnt      <= '0;
      run      <= 1'b0;
      div_out  <= 1'b0;
      act_code <= div_code;
      act_sel  <= src_sel;
    end else if (tick) begin
      if (wrap) begin
        cnt      <= '0;
        run      <= 1'b1;
        div_out  <= 1'b1;
        act_code <= div_code;
        act_sel  <= src_sel;
      end else begin
        cnt     <= nxt[CW-1:0];
        div_out <= (nxt < hi_len);
      end
    end
  end
endmodule

// File: rtl/coded_clk_div_chk.sv
module coded_clk_div_chk #(
  parameter int CODE_W = 3,
  parameter int SEL_W  = 2,
  parameter int NSRC   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_tick,
  input logic              gate_en,
  input logic              div_out,
  input logic [CODE_W-1:0] act_code,
  input logic [SEL_W-1:0]  act_sel
);
  p_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !div_out);

  p_rise_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_out) |-> ($past(gate_en) && ($past(src_tick) != '0)));

  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (src_tick == '0)) |=> $stable(div_out));

  p_code_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> (!$past(gate_en) || $rose(div_out)));

  p_sel_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_sel) |-> (!$past(gate_en) || $rose(div_out)));

  always_comb
    if (!rst_n) p_reset_low_r10: assert (!div_out);
endmodule

bind coded_clk_div coded_clk_div_chk #(
  .CODE_W(CODE_W), .SEL_W(SEL_W), .NSRC(NSRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .gate_en(gate_en),
  .div_out(div_out), .act_code(act_code), .act_sel(act_sel)
);

// File: tb/tb_coded_clk_div.sv
module tb_coded_clk_div;
  localparam int CLK_P = 10;
  localparam int EXP_R [0:7][0:3] = '{
    '{2, 4, 2, 4},   '{4, 8, 2, 4},   '{6, 12, 3, 6},  '{8, 16, 4, 8},
    '{10, 20, 5, 10}, '{12, 24, 6, 12}, '{14, 28, 7, 14}, '{16, 32, 8, 16}
  };

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] src_tick = '0;
  logic [1:0] src_sel = '0;
  logic [2:0] div_code = '0;
  logic       gate_en = 0;
  logic       o_lin, o_wid, o_eng, o_mac;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  coded_clk_div #(.VARIANT(0)) dut (.clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .src_sel(src_sel), .div_code(div_code), .gate_en(gate_en), .div_out(o_lin));
  coded_clk_div #(.VARIANT(1)) dut_w (.clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .src_sel(src_sel), .div_code(div_code), .gate_en(gate_en), .div_out(o_wid));
  coded_clk_div #(.VARIANT(2)) dut_e (.clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .src_sel(src_sel), .div_code(div_code), .gate_en(gate_en), .div_out(o_eng));
  coded_clk_div #(.VARIANT(3)) dut_m (.clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .src_sel(src_sel), .div_code(div_code), .gate_en(gate_en), .div_out(o_mac));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic [127:0] tr, output int hi, output int lo);
    int i;
    i = 1; hi = 0; lo = 0;
    while (i < 128 && !tr[i]) i++;
    while (i < 128 && tr[i]) begin hi++; i++; end
    while (i < 128 && !tr[i]) begin lo++; i++; end
  endtask

  task automatic gate_off(input int n);
    gate_en = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic src_run(input logic [1:0] s, input logic [2:0] t, input int n, output int seen);
    src_tick = '0; src_sel = s; div_code = 3'd0;
    gate_off(2);
    gate_en = 1; src_tick = t; seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (o_lin) seen = 1;
    end
  endtask

  initial begin
    repeat (CLK_P * 100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] tl, tw, te, tm;
    int hi, lo, seen;

    repeat (3) @(negedge clk);
    chk("R10 reset low lin", o_lin, 0);
    chk("R10 reset low all", o_wid | o_eng | o_mac, 0);
    rst_n = 1;
    @(negedge clk);

    for (int c = 0; c < 8; c++) begin
      div_code = 3'(c); src_sel = 2'd0; src_tick = 3'b111;
      gate_off(2);
      tl[0] = o_lin; tw[0] = o_wid; te[0] = o_eng; tm[0] = o_mac;
      gate_en = 1;
      for (int i = 1; i < 128; i++) begin
        @(negedge clk);
        tl[i] = o_lin; tw[i] = o_wid; te[i] = o_eng; tm[i] = o_mac;
      end
      measure(tl, hi, lo);
      chk($sformatf("R1 lin period code %0d", c), hi + lo, EXP_R[c][0]);
      chk($sformatf("R5 lin high code %0d", c), hi, (EXP_R[c][0] + 1) / 2);
      measure(tw, hi, lo);
      chk($sformatf("R2 wide period code %0d", c), hi + lo, EXP_R[c][1]);
      chk($sformatf("R5 wide high code %0d", c), hi, (EXP_R[c][1] + 1) / 2);
      measure(te, hi, lo);
      chk($sformatf("R3 engine period code %0d", c), hi + lo, EXP_R[c][2]);
      chk($sformatf("R5 engine high code %0d", c), hi, (EXP_R[c][2] + 1) / 2);
      measure(tm, hi, lo);
      chk($sformatf("R4 mac period code %0d", c), hi + lo, EXP_R[c][3]);
      chk($sformatf("R5 mac high code %0d", c), hi, (EXP_R[c][3] + 1) / 2);
    end

    src_run(2'd1, 3'b001, 10, seen); chk("R6 sel1 ignores bit0", seen, 0);
    src_run(2'd1, 3'b010, 10, seen); chk("R6 sel1 counts bit1", seen, 1);
    src_run(2'd2, 3'b011, 10, seen); chk("R6 sel2 ignores bits0,1", seen, 0);
    src_run(2'd2, 3'b100, 10, seen); chk("R6 sel2 counts bit2", seen, 1);
    src_run(2'd3, 3'b001, 10, seen); chk("R6 sel3 counts bit0", seen, 1);
    src_run(2'd3, 3'b110, 10, seen); chk("R6 sel3 ignores bits1,2", seen, 0);
    src_run(2'd0, 3'b110, 10, seen); chk("R6 sel0 ignores bits1,2", seen, 0);

    src_tick = 3'b111; src_sel = 2'd0; div_code = 3'd3;
    gate_off(2);
    gate_en = 1;
    tl = '0;
    for (int i = 1; i < 12; i++) begin
      @(negedge clk);
      tl[i] = o_lin;
      if (i == 2) div_code = 3'd0;
    end
    chk("R7 old ratio high phase", int'(tl[4:1]), 4'hF);
    chk("R7 old ratio low phase", int'(tl[8:5]), 0);
    chk("R7 new ratio after rise", int'(tl[11:9]), 3'b101);

    div_code = 3'd3;
    gate_off(2);
    gate_en = 1;
    repeat (2) @(negedge clk);
    chk("R8 running high before gate", o_lin, 1);
    gate_en = 0;
    @(negedge clk);
    chk("R8 low one clock after gate off", o_lin, 0);
    repeat (5) @(negedge clk);
    chk("R8 stays low while gated", o_lin, 0);
    gate_en = 1;
    tl = '0;
    for (int i = 1; i < 7; i++) begin
      @(negedge clk);
      tl[i] = o_lin;
    end
    chk("R8 full high phase after restart", int'(tl[4:1]), 4'hF);
    chk("R8 low after restart period", int'(tl[5]), 0);

    gate_off(2);
    gate_en = 1;
    @(negedge clk);
    src_tick = '0;
    repeat (10) @(negedge clk);
    chk("R9 held high without ticks", o_lin, 1);
    gate_en = 0;
    @(negedge clk);
    gate_en = 1;
    repeat (10) @(negedge clk);
    chk("R9 held low without ticks", o_lin, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule